// File: doc/BRIEF.md
# Memory-Mapped ATA Register Bridge

This block turns single accesses on a simple memory-mapped host port into register cycles on an ATA taskfile port. The host sees a 4 KiB window. Each device register sits in its own 16-byte slot, so the slot number is the address with its low four bits dropped. Byte accesses reach the taskfile registers and the control/status pair. Half-word and word accesses reach only the data port, and the bridge reverses their byte order in both directions. This lets a big-endian host move little-endian ATA data without swapping it in software.

The host request side is valid/ready. A request is taken on a rising edge when `req_valid` and `req_ready` are both high. In the cycle after that edge, the bridge holds `req_ready` low while it drives the single device strobe. The host must keep its request stable while `req_ready` is low. Reads return their data one cycle after the strobe cycle, marked by a one-cycle `rsp_valid`. There is no response back-pressure. Writes give no response.

Top module: `mmio_ata_bridge`

## Requirements
- R1: The slot number is address bits 11:4. Bits 3:0 and every bit above 11 have no effect on routing, so the window aliases across the whole address space.
- R2: A byte access (size code 0) at slot 1 to 7 strobes the taskfile select (`dev_sel_ctl`=0) with `dev_reg` equal to the slot. Write data goes out in bits 7:0. A read returns the device's bits 7:0, zero-extended.
- R3: A byte access at slot 8 or slot 22 strobes the control select (`dev_sel_ctl`=1) with `dev_reg`=6. A write reaches the device control register. A read returns the alternate status, zero-extended from bits 7:0.
- R4: A byte access at any other slot strobes nothing. A read of it returns 0x000000FF.
- R5: Half-word (size code 1) and word (size code 2) accesses are honoured only at slot 0. That is the data port: `dev_reg`=0, `dev_sel_ctl`=0, and `dev_wide` is 1 for a word and 0 for a half-word. At other slots nothing is strobed, and reads return 0x0000FFFF (half-word) or 0xFFFFFFFF (word).
- R6: Data-port data is byte-reversed in both directions. For a half-word, the two bytes of bits 15:0 swap and bits 31:16 are zero. For a word, all four bytes reverse. Byte accesses are never swapped.
- R7: Size code 3 strobes nothing at any slot. A read with this code returns 0xFFFFFFFF.
- R8: An accepted request makes exactly one strobe cycle, in the cycle after acceptance: `dev_wr` for a write and `dev_rd` for a read, never both. A read gives `rsp_valid` for exactly one cycle, in the cycle after the strobe cycle. A write never gives `rsp_valid`.
- R9: After reset, `req_ready` is high, and `rsp_valid`, `dev_rd` and `dev_wr` are low. `req_ready` is low in the cycle after each acceptance and high again in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Bridge can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| req_addr | input | ADDR_W | Host byte address |
| req_wdata | input | 32 | Host write data, right-aligned |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 32 | Read data |
| dev_sel_ctl | output | 1 | 0 = taskfile select, 1 = control select |
| dev_reg | output | 3 | Device register number |
| dev_wide | output | 1 | Data port access is 32 bits |
| dev_wr | output | 1 | Device write strobe |
| dev_rd | output | 1 | Device read strobe |
| dev_wdata | output | 32 | Data to the device |
| dev_rdata | input | 32 | Data from the device, sampled during `dev_rd` |

## Verification
The routing is tested with random addresses. These mix random upper bits and random low nibbles over every slot number, with extra weight on slots 0 to 8, 22 and their neighbours. Any route that depends on ignored bits would then differ between aliases. Each size code is paired with both directions. This separates the taskfile route, the control alias, the data port and the dropped cases, and shows which strobe fires. Random write data and random device read data with four distinct bytes show a missing or wrong byte swap. Directed cases cover slots 7, 8, 9, 22, 23, the far end of the window and size code 3.

// File: rtl/mab_pkg.sv
package mab_pkg;
  localparam int DATA_W = 32;
  localparam logic [2:0] CTRL_REG_NO = 3'd6;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_TASK = 2'd1,
    TGT_CTRL = 2'd2,
    TGT_DATA = 2'd3
  } tgt_e;

  typedef struct packed {
    tgt_e       tgt;
    logic [2:0] reg_no;
    logic       wide;
  } route_t;
endpackage

// File: rtl/mab_route.sv
module mab_route
  import mab_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WIN_BITS   = 12,
  parameter int SLOT_SHIFT = 4,
  parameter int CTL_IDX_A  = 8,
  parameter int CTL_IDX_B  = 22
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output route_t            route
);
  localparam int IDX_W = WIN_BITS - SLOT_SHIFT;
  localparam logic [IDX_W-1:0] IDX_CA = CTL_IDX_A[IDX_W-1:0];
  localparam logic [IDX_W-1:0] IDX_CB = CTL_IDX_B[IDX_W-1:0];
  localparam logic [IDX_W-1:0] IDX_LO = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_HI = IDX_W'(7);

  logic [IDX_W-1:0] slot;
  size_e            sz;

  assign slot = addr[WIN_BITS-1:SLOT_SHIFT];
  assign sz   = size_e'(size);

  always_comb begin
    route = '{tgt: TGT_NONE, reg_no: 3'd0, wide: 1'b0};
    unique case (sz)
      SZ_BYTE: begin
        if (slot >= IDX_LO && slot <= IDX_HI) begin
          route.tgt    = TGT_TASK;
          route.reg_no = slot[2:0];
        end else if (slot == IDX_CA || slot == IDX_CB) begin
          route.tgt    = TGT_CTRL;
          route.reg_no = CTRL_REG_NO;
        end
      end
      SZ_HALF, SZ_WORD: begin
        if (slot == '0) begin
          route.tgt  = TGT_DATA;
          route.wide = (sz == SZ_WORD);
        end
      end
      default: route.tgt = TGT_NONE;
    endcase
  end
endmodule

// File: rtl/mab_swap.sv
module mab_swap #(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] din,
  output logic [8*LANES-1:0] dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dout[8*g +: 8] = din[8*(LANES-1-g) +: 8];
  end
endmodule

// File: rtl/mmio_ata_bridge.sv
module mmio_ata_bridge
  import mab_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WIN_BITS   = 12,
  parameter int SLOT_SHIFT = 4,
  parameter int CTL_IDX_A  = 8,
  parameter int CTL_IDX_B  = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              dev_sel_ctl,
  output logic [2:0]        dev_reg,
  output logic              dev_wide,
  output logic              dev_wr,
  output logic              dev_rd,
  output logic [31:0]       dev_wdata,
  input  logic [31:0]       dev_rdata
);
  localparam int HW = DATA_W / 2;

  route_t            rt;
  logic              take;
  logic [HW-1:0]     wr_sw16, rd_sw16;
  logic [DATA_W-1:0] wr_sw32, rd_sw32;
  logic [DATA_W-1:0] wr_fmt, rd_fmt;

  logic              s1_vld;
  logic              s1_write;
  size_e             s1_size;
  route_t            s1_rt;
  logic [DATA_W-1:0] s1_wdata;

  mab_route #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .SLOT_SHIFT(SLOT_SHIFT),
    .CTL_IDX_A(CTL_IDX_A), .CTL_IDX_B(CTL_IDX_B)
  ) route_i (
    .addr(req_addr), .size(req_size), .route(rt)
  );

  mab_swap #(.LANES(2)) wsw16_i (.din(req_wdata[HW-1:0]), .dout(wr_sw16));
  mab_swap #(.LANES(4)) wsw32_i (.din(req_wdata),         .dout(wr_sw32));
  mab_swap #(.LANES(2)) rsw16_i (.din(dev_rdata[HW-1:0]), .dout(rd_sw16));
  mab_swap #(.LANES(4)) rsw32_i (.din(dev_rdata),         .dout(rd_sw32));

  assign req_ready = ~s1_vld;
  assign take      = req_valid & req_ready;

  always_comb begin
    unique case (size_e'(req_size))
      SZ_HALF: wr_fmt = {{HW{1'b0}}, wr_sw16};
      SZ_WORD: wr_fmt = wr_sw32;
      default: wr_fmt = {{(DATA_W-8){1'b0}}, req_wdata[7:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_write <= 1'b0;
      s1_size  <= SZ_BYTE;
      s1_rt    <= '{tgt: TGT_NONE, reg_no: 3'd0, wide: 1'b0};
      s1_wdata <= '0;
    end else begin
      s1_vld <= take;
      if (take) begin
        s1_write <= req_write;
        s1_size  <= size_e'(req_size);
        s1_rt    <= rt;
        s1_wdata <= wr_fmt;
      end
    end
  end

  assign dev_wr      = s1_vld &  s1_write & (s1_rt.tgt != TGT_NONE);
  assign dev_rd      = s1_vld & ~s1_write & (s1_rt.tgt != TGT_NONE);
  assign dev_sel_ctl = (s1_rt.tgt == TGT_CTRL);
  assign dev_reg     = s1_rt.reg_no;
  assign dev_wide    = s1_rt.wide;
  assign dev_wdata   = s1_wdata;

  always_comb begin
    unique case (s1_rt.tgt)
      TGT_TASK, TGT_CTRL: rd_fmt = {{(DATA_W-8){1'b0}}, dev_rdata[7:0]};
      TGT_DATA:           rd_fmt = s1_rt.wide ? rd_sw32 : {{HW{1'b0}}, rd_sw16};
      default: begin
        unique case (s1_size)
          SZ_BYTE: rd_fmt = 32'h0000_00FF;
          SZ_HALF: rd_fmt = 32'h0000_FFFF;
          default: rd_fmt = 32'hFFFF_FFFF;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= s1_vld & ~s1_write;
      if (s1_vld & ~s1_write) rsp_rdata <= rd_fmt;
    end
  end
endmodule

// File: rtl/mab_checker.sv
module mab_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       dev_sel_ctl,
  input logic [2:0] dev_reg,
  input logic       dev_wide,
  input logic       dev_wr,
  input logic       dev_rd
);
  a_r8_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_rd && dev_wr));

  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rd || dev_wr) |=> !(dev_rd || dev_wr));

  a_r8_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rd |=> rsp_valid);

  a_r8_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r9_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r9_ready_returns: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready);

  a_r5_data_port_target: assert property (@(posedge clk) disable iff (!rst_n)
    ((dev_rd || dev_wr) && dev_wide) |-> (dev_reg == 3'd0 && !dev_sel_ctl));

  a_r3_ctrl_target: assert property (@(posedge clk) disable iff (!rst_n)
    ((dev_rd || dev_wr) && dev_sel_ctl) |-> (dev_reg == 3'd6));
endmodule

bind mmio_ata_bridge mab_checker chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .dev_sel_ctl(dev_sel_ctl), .dev_reg(dev_reg),
  .dev_wide(dev_wide), .dev_wr(dev_wr), .dev_rd(dev_rd)
);

// File: tb/mmio_ata_bridge_tb_top.sv
module mmio_ata_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        dev_sel_ctl;
  logic [2:0]  dev_reg;
  logic        dev_wide;
  logic        dev_wr;
  logic        dev_rd;
  logic [31:0] dev_wdata;
  logic [31:0] dev_rdata = '0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mmio_ata_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dev_sel_ctl(dev_sel_ctl), .dev_reg(dev_reg), .dev_wide(dev_wide),
    .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // kind: 0 none, 1 taskfile, 2 control, 3 data port
  function automatic int exp_kind(input logic [1:0] sz, input logic [31:0] a);
    int s = int'((a & 32'hFFF) >> 4);
    if (sz == 2'd0) begin
      if (s >= 1 && s <= 7) return 1;
      if (s == 8 || s == 22) return 2;
      return 0;
    end
    if ((sz == 2'd1 || sz == 2'd2) && s == 0) return 3;
    return 0;
  endfunction

  function automatic logic [31:0] swap16(input logic [31:0] v);
    return {16'h0, v[7:0], v[15:8]};
  endfunction

  function automatic logic [31:0] swap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic string kind_tag(input int k, input logic [1:0] sz);
    if (sz == 2'd3) return "R7";
    case (k)
      1: return "R2";
      2: return "R3";
      3: return "R6";
      default: return (sz == 2'd0) ? "R4" : "R5";
    endcase
  endfunction

  task automatic access(input bit w, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] wd, input logic [31:0] devv);
    int k = exp_kind(sz, a);
    bit hit = (k != 0);
    string tg = kind_tag(k, sz);
    logic [31:0] ew, er;
    ew = (k == 3) ? ((sz == 2'd2) ? swap32(wd) : swap16(wd)) : {24'h0, wd[7:0]};
    if (k == 1 || k == 2) er = {24'h0, devv[7:0]};
    else if (k == 3) er = (sz == 2'd2) ? swap32(devv) : swap16(devv);
    else er = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = wd;
    dev_rdata = devv;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9 ready low after accept", {31'h0, req_ready}, 32'h0);
    chk(dev_wr == (w && hit), {tg, " R8 write strobe"}, {31'h0, dev_wr}, {31'h0, w && hit});
    chk(dev_rd == (!w && hit), {tg, " R8 read strobe"}, {31'h0, dev_rd}, {31'h0, !w && hit});
    if (hit) begin
      logic [2:0] er_reg = (k == 1) ? 3'(((a & 32'hFFF) >> 4)) : (k == 2) ? 3'd6 : 3'd0;
      chk(dev_reg == er_reg, {tg, " register number"}, {29'h0, dev_reg}, {29'h0, er_reg});
      chk(dev_sel_ctl == (k == 2), {tg, " select"}, {31'h0, dev_sel_ctl}, {31'h0, k == 2});
      if (k == 3) chk(dev_wide == (sz == 2'd2), "R5 width", {31'h0, dev_wide}, {31'h0, sz == 2'd2});
      if (w) chk(dev_wdata == ew, {tg, " write data"}, dev_wdata, ew);
    end
    @(negedge clk);
    chk(rsp_valid == !w, "R8 response valid", {31'h0, rsp_valid}, {31'h0, !w});
    chk(!dev_rd && !dev_wr, "R8 single strobe", {30'h0, dev_rd, dev_wr}, 32'h0);
    chk(req_ready == 1'b1, "R9 ready returns", {31'h0, req_ready}, 32'h1);
    if (!w) chk(rsp_rdata == er, {tg, " read data"}, rsp_rdata, er);
  endtask

  function automatic logic [31:0] rand_addr();
    int pick = int'($urandom_range(0, 9));
    logic [7:0] s;
    if (pick < 6) s = 8'($urandom_range(0, 9));
    else if (pick == 6) s = 8'($urandom_range(21, 23));
    else s = 8'($urandom_range(0, 255));
    return {$urandom_range(0, 32'hFFFFF), 12'h0} | {20'h0, s, 4'($urandom_range(0, 15))};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357_9BDF));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 reset ready", {31'h0, req_ready}, 32'h1);
    chk(!rsp_valid && !dev_rd && !dev_wr, "R9 reset idle", {29'h0, rsp_valid, dev_rd, dev_wr}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && !rsp_valid, "R9 idle after reset", {30'h0, req_ready, rsp_valid}, 32'h2);

    // directed corners
    access(1'b1, 2'd0, 32'h0000_0070, 32'h0000_005A, 32'h0);       // R2 last taskfile slot
    access(1'b0, 2'd0, 32'h0000_0010, 32'h0, 32'hDEAD_BE11);       // R2 first taskfile slot
    access(1'b1, 2'd0, 32'h0000_0080, 32'h0000_0004, 32'h0);       // R3 control, slot 8
    access(1'b0, 2'd0, 32'h0000_0160, 32'h0, 32'h1234_5650);       // R3 alias, slot 22
    access(1'b0, 2'd0, 32'h0000_0090, 32'h0, 32'h0);               // R4 slot 9
    access(1'b1, 2'd0, 32'h0000_0170, 32'hAB, 32'h0);              // R4 slot 23 write dropped
    access(1'b0, 2'd0, 32'h0000_0000, 32'h0, 32'h0);               // R4 byte at data port
    access(1'b0, 2'd1, 32'h0000_0FF0, 32'h0, 32'h0);               // R5 far end of window
    access(1'b0, 2'd2, 32'h0000_0010, 32'h0, 32'h0);               // R5 word off data port
    access(1'b1, 2'd1, 32'h0000_0000, 32'hCAFE_1234, 32'h0);       // R6 half swap
    access(1'b0, 2'd2, 32'h0000_0004, 32'h0, 32'h0102_0304);       // R6 word swap
    access(1'b1, 2'd2, 32'h0000_0000, 32'h1122_3344, 32'h0);       // R6 word write swap
    access(1'b0, 2'd3, 32'h0000_0000, 32'h0, 32'h0);               // R7
    access(1'b1, 2'd3, 32'h0000_0030, 32'h77, 32'h0);              // R7
    access(1'b0, 2'd0, 32'hFFFF_F03C, 32'h0, 32'h0000_00C3);       // R1 alias, slot 3
    access(1'b1, 2'd2, 32'h8000_A00F, 32'h89AB_CDEF, 32'h0);       // R1 alias data port

    for (int i = 0; i < 600; i++) begin
      access(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), rand_addr(),
             $urandom, $urandom);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule